// File: doc/BRIEF.md
# Ring-Oscillator Voltage Meter with Runtime Ladder Calibration

This block measures a voltage by counting the rising edges of a voltage-controlled ring oscillator during a gate window of a programmable number of reference clock cycles. A higher voltage makes the oscillator faster, so the count grows with the voltage. The raw count is not linear in the voltage, and it changes from part to part. For that reason the block first runs a calibration pass. In that pass it drives the oscillator from an on-die reference ladder, one tap per window, and stores the count for every tap in a table.

In a measurement pass, the oscillator input multiplexer is set to the selected source. The block takes the edge count, finds the table segment that holds it, and reports the voltage in whole millivolts. The value is the segment's lower ladder voltage plus a rounded linear share of one ladder step. A count outside the calibrated range is clamped to the nearest end voltage and flagged. All logic runs on the block's own free-running reference clock. The oscillator signal arrives asynchronously and passes through a multi-flop synchronizer before edge detection.

Top module: `vco_volt_meter`

## Requirements
- R1: After reset, `done`, `volt_mv`, `out_of_range`, `cal_err`, `ladder_idx` and `mux_sel` are all zero.
- R2: Each low-to-high transition of `vco_in` whose high and low phases each last at least one clock cycle, and that falls inside the gate window, adds exactly one to the count. The gate window is `gate_cycles` cycles long; a value of 0 is treated as 1.
- R3: A `start` with `cal_mode`=1 runs NPTS consecutive windows. During window k, `ladder_idx` equals k and `mux_sel` is all ones (the ladder code). The count of window k is stored as table entry k. `done` pulses NPTS*`gate_cycles` cycles after the start edge, and `ladder_idx` then returns to 0.
- R4: `cal_err` is cleared when a calibration starts. It is set if any stored entry k>0 is less than or equal to entry k-1.
- R5: A `start` with `cal_mode`=0 latches `in_sel` onto `mux_sel` for the whole measurement. `done` pulses exactly `gate_cycles`+CNT_W+STEP_W+2 cycles after the start edge (626 cycles for a 600-cycle gate with the default widths).
- R6: Ladder tap k stands for REF_BASE_MV+k*REF_STEP_MV millivolts (991+8k by default). A count c with entry0 <= c <= entryN-1 reports V_j + round((c-e_j)*REF_STEP_MV/(e_(j+1)-e_j)). Here j is the largest index no greater than NPTS-2 with e_j <= c, and an exact half rounds up. For example, with 1015 mV at count 150 and 1023 mV at count 190, a count of 155 gives 1016 mV.
- R7: A count below entry 0 reports the tap-0 voltage, and a count above the last entry reports the last tap's voltage. In both cases `out_of_range` is 1. It is 0 for counts inside the table.
- R8: `start` is ignored while a pass is running. It changes neither the result, nor its timing, nor `ladder_idx`.
- R9: `done` is a single-cycle pulse. `volt_mv` and `out_of_range` keep their values until the next measurement result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock that defines the gate window |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass when idle |
| cal_mode | input | 1 | With start: 1 = calibration pass, 0 = measurement |
| in_sel | input | SEL_W | Oscillator source for a measurement |
| gate_cycles | input | GATE_W | Gate window length in clock cycles |
| vco_in | input | 1 | Asynchronous oscillator output |
| mux_sel | output | SEL_W | Oscillator input multiplexer select |
| ladder_idx | output | $clog2(NPTS) | Reference ladder tap being applied |
| done | output | 1 | One-cycle pulse when a pass finishes |
| volt_mv | output | MV_W | Measured voltage in millivolts |
| out_of_range | output | 1 | Last measurement was clamped |
| cal_err | output | 1 | Last calibration produced a non-increasing table |

## Verification
A calibration finishes NPTS*gate cycles after its start edge. A measurement finishes gate+26 cycles after its start edge: one search cycle, 24 divider steps and one output register. The bench numbers every rising edge and records the edge after which `done` is first seen. It compares that edge number with these exact figures and reads `volt_mv` and the flags in the same cycle. Oscillator pulses start four cycles into each window and stop well before its end, so the synchronizer delay cannot move an edge into a neighbouring window. The bench computes every expected voltage from the table it programmed, using integer round-half-up arithmetic.

// File: rtl/vmeter_pkg.sv
package vmeter_pkg;
   typedef enum logic [1:0] {
      VM_IDLE,
      VM_GATE,
      VM_SRCH,
      VM_DIV
   } vm_state_e;
endpackage

// File: rtl/vmeter_edge_sync.sv
// Multi-flop synchronizer followed by rising-edge detection.
module vmeter_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("vmeter_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[s] <= 1'b0;
            else        sh[s] <= sh[s-1];
         end
      end
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/vmeter_cal_table.sv
// Calibration count table with a parallel segment search.
module vmeter_cal_table #(
   parameter int NPTS  = 8,
   parameter int CNT_W = 16,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic [CNT_W-1:0] key,
   output logic [CNT_W-1:0] prev_cnt,
   output logic             below,
   output logic             above,
   output logic [IDX_W-1:0] seg,
   output logic [CNT_W-1:0] c_lo,
   output logic [CNT_W-1:0] c_hi
);
   logic [CNT_W-1:0] tbl [NPTS];

   for (genvar k = 0; k < NPTS; k++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              tbl[k] <= '0;
         else if (wr_en && wr_idx == IDX_W'(k))   tbl[k] <= wr_cnt;
      end
   end

   assign prev_cnt = (wr_idx == '0) ? '0 : tbl[wr_idx - 1'b1];
   assign below    = key < tbl[0];
   assign above    = key > tbl[NPTS-1];

   always_comb begin
      seg = '0;
      for (int j = 1; j <= NPTS - 2; j++) begin
         if (key >= tbl[j]) seg = IDX_W'(j);
      end
   end

   assign c_lo = tbl[seg];
   assign c_hi = tbl[seg + 1'b1];
endmodule

// File: rtl/vmeter_rdiv.sv
// Restoring divider: one quotient bit per cycle, fixed latency NUM_W.
module vmeter_rdiv #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quo,
   output logic             fin
);
   localparam int K_W = $clog2(NUM_W + 1);

   logic [DEN_W:0]   rem;
   logic [DEN_W:0]   rem_sh;
   logic [NUM_W-1:0] q;
   logic [DEN_W-1:0] den_q;
   logic [K_W-1:0]   k;

   assign rem_sh = {rem[DEN_W-1:0], q[NUM_W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         q     <= '0;
         den_q <= '0;
         k     <= '0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            rem   <= '0;
            q     <= num;
            den_q <= den;
            k     <= K_W'(NUM_W);
         end else if (k != '0) begin
            if (rem_sh >= {1'b0, den_q}) begin
               rem <= rem_sh - {1'b0, den_q};
               q   <= {q[NUM_W-2:0], 1'b1};
            end else begin
               rem <= rem_sh;
               q   <= {q[NUM_W-2:0], 1'b0};
            end
            k   <= k - 1'b1;
            fin <= (k == K_W'(1));
         end
      end
   end

   assign quo = q;
endmodule

// File: rtl/vco_volt_meter.sv
module vco_volt_meter #(
   parameter int NPTS        = 8,
   parameter int CNT_W       = 16,
   parameter int GATE_W      = 16,
   parameter int MV_W        = 16,
   parameter int STEP_W      = 8,
   parameter int SEL_W       = 3,
   parameter int REF_BASE_MV = 991,
   parameter int REF_STEP_MV = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(NPTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cal_mode,
   input  logic [SEL_W-1:0]  in_sel,
   input  logic [GATE_W-1:0] gate_cycles,
   input  logic              vco_in,
   output logic [SEL_W-1:0]  mux_sel,
   output logic [IDX_W-1:0]  ladder_idx,
   output logic              done,
   output logic [MV_W-1:0]   volt_mv,
   output logic              out_of_range,
   output logic              cal_err
);
   import vmeter_pkg::*;

   localparam int NUM_W   = CNT_W + STEP_W;
   localparam int V_TOP   = REF_BASE_MV + (NPTS - 1) * REF_STEP_MV;
   localparam logic [SEL_W-1:0] LADDER_CODE = {SEL_W{1'b1}};

   if (NPTS < 2) begin : g_bad_npts
      $error("vco_volt_meter: NPTS must be at least 2");
   end
   if (REF_STEP_MV >= (1 << STEP_W)) begin : g_bad_step
      $error("vco_volt_meter: REF_STEP_MV does not fit STEP_W");
   end
   if (V_TOP >= (1 << MV_W)) begin : g_bad_mv
      $error("vco_volt_meter: ladder top does not fit MV_W");
   end
   if (GATE_W > CNT_W + 1) begin : g_bad_gate
      $error("vco_volt_meter: GATE_W too wide for CNT_W");
   end

   vm_state_e         state;
   logic [GATE_W-1:0] timer, gate_q;
   logic [CNT_W-1:0]  cnt, cnt_next, key_q;
   logic              cal_q, oor_pend;
   logic [SEL_W-1:0]  sel_q;
   logic [IDX_W-1:0]  idx;
   logic [MV_W-1:0]   base_q;
   logic              rise, last_win, in_gate;

   logic              tb_below, tb_above;
   logic [IDX_W-1:0]  tb_seg;
   logic [CNT_W-1:0]  tb_lo, tb_hi, tb_prev;
   logic              wr_en;

   logic [CNT_W-1:0]  span, diff;
   logic              degen;
   logic [CNT_W-1:0]  den_eff;
   logic [NUM_W-1:0]  num_eff;
   logic [MV_W-1:0]   base_mv;
   logic              dv_load, dv_fin;
   logic [NUM_W-1:0]  dv_quo;

   vmeter_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(vco_in), .rise(rise)
   );

   assign cnt_next = cnt + CNT_W'(rise);
   assign last_win = (timer == GATE_W'(1));
   assign in_gate  = (state == VM_GATE);
   assign wr_en    = in_gate && cal_q && last_win;

   vmeter_cal_table #(.NPTS(NPTS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(idx), .wr_cnt(cnt_next),
      .key(key_q), .prev_cnt(tb_prev),
      .below(tb_below), .above(tb_above), .seg(tb_seg),
      .c_lo(tb_lo), .c_hi(tb_hi)
   );

   // Segment arithmetic: numerator carries half the divisor for rounding.
   assign span    = tb_hi - tb_lo;
   assign diff    = key_q - tb_lo;
   assign degen   = tb_below | tb_above | (span == '0);
   assign den_eff = degen ? CNT_W'(1) : span;
   assign num_eff = degen ? '0
                  : NUM_W'(diff) * NUM_W'(REF_STEP_MV) + NUM_W'(span >> 1);
   assign base_mv = tb_below ? MV_W'(REF_BASE_MV)
                  : tb_above ? MV_W'(V_TOP)
                  : MV_W'(REF_BASE_MV) + MV_W'(tb_seg) * MV_W'(REF_STEP_MV);
   assign dv_load = (state == VM_SRCH);

   vmeter_rdiv #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .load(dv_load),
      .num(num_eff), .den(den_eff), .quo(dv_quo), .fin(dv_fin)
   );

   assign mux_sel    = cal_q ? LADDER_CODE : sel_q;
   assign ladder_idx = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= VM_IDLE;
         timer        <= '0;
         gate_q       <= '0;
         cnt          <= '0;
         key_q        <= '0;
         cal_q        <= 1'b0;
         sel_q        <= '0;
         idx          <= '0;
         base_q       <= '0;
         oor_pend     <= 1'b0;
         done         <= 1'b0;
         volt_mv      <= '0;
         out_of_range <= 1'b0;
         cal_err      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            VM_IDLE: begin
               if (start) begin
                  gate_q <= (gate_cycles == '0) ? GATE_W'(1) : gate_cycles;
                  timer  <= (gate_cycles == '0) ? GATE_W'(1) : gate_cycles;
                  cnt    <= '0;
                  cal_q  <= cal_mode;
                  idx    <= '0;
                  if (cal_mode) cal_err <= 1'b0;
                  else          sel_q   <= in_sel;
                  state  <= VM_GATE;
               end
            end
            VM_GATE: begin
               if (last_win) begin
                  if (cal_q) begin
                     if (idx != '0 && cnt_next <= tb_prev) cal_err <= 1'b1;
                     if (idx == IDX_W'(NPTS - 1)) begin
                        state <= VM_IDLE;
                        done  <= 1'b1;
                        idx   <= '0;
                        cal_q <= 1'b0;
                     end else begin
                        idx   <= idx + 1'b1;
                        timer <= gate_q;
                        cnt   <= '0;
                     end
                  end else begin
                     key_q <= cnt_next;
                     state <= VM_SRCH;
                  end
               end else begin
                  timer <= timer - 1'b1;
                  cnt   <= cnt_next;
               end
            end
            VM_SRCH: begin
               base_q   <= base_mv;
               oor_pend <= tb_below | tb_above;
               state    <= VM_DIV;
            end
            VM_DIV: begin
               if (dv_fin) begin
                  volt_mv      <= base_q + MV_W'(dv_quo);
                  out_of_range <= oor_pend;
                  done         <= 1'b1;
                  state        <= VM_IDLE;
               end
            end
            default: state <= VM_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vmeter_chk.sv
module vmeter_chk #(
   parameter int NPTS        = 8,
   parameter int MV_W        = 16,
   parameter int SEL_W       = 3,
   parameter int IDX_W       = 3,
   parameter int NUM_W       = 24,
   parameter int REF_BASE_MV = 991,
   parameter int REF_STEP_MV = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic [MV_W-1:0]  volt_mv,
   input logic             out_of_range,
   input logic [IDX_W-1:0] ladder_idx,
   input logic [SEL_W-1:0] mux_sel,
   input logic             in_gate,
   input logic             dv_fin,
   input logic [NUM_W-1:0] dv_quo
);
   localparam int V_TOP = REF_BASE_MV + (NPTS - 1) * REF_STEP_MV;

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_of_range != $past(out_of_range)) |-> done);

   assert_volt_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dv_fin |=> (volt_mv >= MV_W'(REF_BASE_MV) && volt_mv <= MV_W'(V_TOP)));

   assert_quot_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dv_fin |-> (dv_quo <= NUM_W'(REF_STEP_MV)));

   assert_ladder_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ladder_idx != $past(ladder_idx)) |->
         (ladder_idx == $past(ladder_idx) + 1'b1 || ladder_idx == '0));

   assert_sel_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_gate && $past(in_gate)) |-> $stable(mux_sel));
endmodule

bind vco_volt_meter vmeter_chk #(
   .NPTS(NPTS), .MV_W(MV_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .NUM_W(NUM_W),
   .REF_BASE_MV(REF_BASE_MV), .REF_STEP_MV(REF_STEP_MV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .volt_mv(volt_mv),
   .out_of_range(out_of_range), .ladder_idx(ladder_idx), .mux_sel(mux_sel),
   .in_gate(in_gate), .dv_fin(dv_fin), .dv_quo(dv_quo)
);

// File: tb/tb_vco_volt_meter.sv
module tb_vco_volt_meter;
   localparam int NPTS = 8, CNT_W = 16, GATE_W = 16, MV_W = 16;
   localparam int STEP_W = 8, SEL_W = 3, IDX_W = 3;
   localparam int NUM_W = CNT_W + STEP_W;
   localparam int G = 600;

   logic              clk = 1'b0, rst_n = 1'b0, start = 1'b0, cal_mode = 1'b0;
   logic [SEL_W-1:0]  in_sel = '0;
   logic [GATE_W-1:0] gate = GATE_W'(G);
   logic              vco_in = 1'b0;
   logic [SEL_W-1:0]  mux_sel;
   logic [IDX_W-1:0]  ladder_idx;
   logic              done, out_of_range, cal_err;
   logic [MV_W-1:0]   volt_mv;

   vco_volt_meter dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cal_mode(cal_mode),
      .in_sel(in_sel), .gate_cycles(gate), .vco_in(vco_in),
      .mux_sel(mux_sel), .ladder_idx(ladder_idx), .done(done),
      .volt_mv(volt_mv), .out_of_range(out_of_range), .cal_err(cal_err)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int done_cyc = 0;
   bit done_seen = 1'b0;
   always @(negedge clk) if (done) begin done_seen = 1'b1; done_cyc = cyc; end

   int checks = 0, errors = 0;
   int good_tbl[NPTS] = '{60, 90, 125, 150, 190, 230, 246, 280};
   int bad_tbl[NPTS]  = '{60, 90, 80, 150, 190, 230, 246, 280};

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_mv(int c, output bit oor);
      int j = 0, d;
      if (c < good_tbl[0]) begin oor = 1'b1; return 991; end
      if (c > good_tbl[NPTS-1]) begin oor = 1'b1; return 991 + 8 * (NPTS - 1); end
      oor = 1'b0;
      for (int k = 1; k <= NPTS - 2; k++) if (c >= good_tbl[k]) j = k;
      d = good_tbl[j+1] - good_tbl[j];
      return 991 + 8 * j + ((c - good_tbl[j]) * 8 + d / 2) / d;
   endfunction

   task automatic pulses(int n);
      for (int i = 0; i < n; i++) begin
         vco_in = 1'b1; @(negedge clk);
         vco_in = 1'b0; @(negedge clk);
      end
   endtask

   task automatic run_cal(int cs[NPTS], bit exp_err);
      int t0;
      @(negedge clk);
      cal_mode = 1'b1; gate = GATE_W'(G); start = 1'b1; done_seen = 1'b0;
      @(negedge clk);
      start = 1'b0; cal_mode = 1'b0; t0 = cyc;
      for (int k = 0; k < NPTS; k++) begin
         chk(ladder_idx == IDX_W'(k), "R3", "ladder tap", int'(ladder_idx), k);
         chk(mux_sel == '1, "R3", "ladder mux code", int'(mux_sel), 7);
         repeat (3) @(negedge clk);
         pulses(cs[k]);
         repeat (G - 3 - 2 * cs[k]) @(negedge clk);
      end
      chk(done == 1'b1, "R3", "cal done timing", int'(done), 1);
      chk(cyc - t0 == NPTS * G, "R3", "cal latency", cyc - t0, NPTS * G);
      chk(cal_err == exp_err, "R4", "cal error flag", int'(cal_err), int'(exp_err));
      @(negedge clk);
      chk(ladder_idx == '0, "R3", "tap after cal", int'(ladder_idx), 0);
   endtask

   task automatic measure(int c, int sel, int g, bit poke);
      int t0, ev;
      bit eo;
      logic [MV_W-1:0] v_hold;
      @(negedge clk);
      in_sel = SEL_W'(sel); gate = GATE_W'(g); start = 1'b1; done_seen = 1'b0;
      @(negedge clk);
      start = 1'b0; t0 = cyc;
      if (poke) begin
         @(negedge clk); start = 1'b1; cal_mode = 1'b1;
         @(negedge clk); start = 1'b0; cal_mode = 1'b0;
         @(negedge clk);
      end else begin
         repeat (3) @(negedge clk);
      end
      chk(mux_sel == SEL_W'(sel), "R5", "source select", int'(mux_sel), sel);
      pulses(c);
      while (!done_seen) @(negedge clk);
      ev = exp_mv(c, eo);
      chk(int'(volt_mv) == ev, "R6", $sformatf("voltage c=%0d", c), int'(volt_mv), ev);
      chk(out_of_range == eo, "R7", $sformatf("range flag c=%0d", c),
          int'(out_of_range), int'(eo));
      chk(done_cyc - t0 == g + NUM_W + 2, "R5", "measure latency",
          done_cyc - t0, g + NUM_W + 2);
      if (poke) chk(ladder_idx == '0, "R8", "tap after ignored start", int'(ladder_idx), 0);
      v_hold = volt_mv;
      @(negedge clk);
      chk(done == 1'b0, "R9", "done single pulse", int'(done), 0);
      chk(volt_mv == v_hold, "R9", "voltage held", int'(volt_mv), int'(v_hold));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(done == 1'b0, "R1", "done", int'(done), 0);
      chk(volt_mv == '0, "R1", "volt", int'(volt_mv), 0);
      chk(out_of_range == 1'b0, "R1", "range flag", int'(out_of_range), 0);
      chk(cal_err == 1'b0, "R1", "cal flag", int'(cal_err), 0);
      chk(ladder_idx == '0, "R1", "ladder tap", int'(ladder_idx), 0);
      chk(mux_sel == '0, "R1", "mux select", int'(mux_sel), 0);

      // R4: non-increasing entry flagged, then cleared by a clean pass
      run_cal(bad_tbl, 1'b1);
      run_cal(good_tbl, 1'b0);

      // R2/R6: exact table counts map to exact tap voltages
      for (int k = 0; k < NPTS; k++) measure(good_tbl[k], k % 7, G, 1'b0);
      // R6: documented segment example and a half-way rounding case
      measure(155, 2, G, 1'b0);
      measure(231, 3, G, 1'b0);
      // R6/R7: sweep across and beyond the table
      for (int c = 50; c <= 292; c += 3) measure(c, c % 7, G, 1'b0);
      // R8: start pulse during a measurement has no effect
      measure(170, 5, G, 1'b1);
      // R2/R7: short gate with no edges clamps low
      measure(0, 1, 40, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule